// File: doc/BRIEF.md
# Windowed Register File

This block is a register file that keeps a large physical pool of registers and shows only a small slice of it to the running procedure. That slice is a window of eight registers. Software addresses registers by a 3-bit logical number. The block forms the physical index from that number and a current-window pointer.

A call strobe moves the pointer to the next window, so the callee gets a fresh set of registers. A return strobe moves the pointer back, and the caller finds its own registers as it left them. Calls and returns therefore need no save or restore traffic to memory.

There are two combinational read ports and one synchronous write port. A call past the last window is blocked and flagged as overflow. A return from window 0 is blocked and flagged as underflow.

Top module: `wrf_top`

## Requirements
- R1: While `rst_ni` is low, the pointer is 0 and both flags are 0, even if `call_i` or `ret_i` is high. Reset is asynchronous.
- R2: A call alone, made below the last window (15), raises `cwp_o` by one after the clock edge.
- R3: A return alone, made above window 0, lowers `cwp_o` by one. After the return, the caller's registers read back with the values they held before the call.
- R4: Physical index = `cwp_o` * 8 + logical number. A write made in one window is not visible in any other window. Window 15, register 7 (physical 127) can be written and read back.
- R5: A call while `cwp_o` is 15 leaves the pointer at 15. `ovf_o` is 1 for exactly the one cycle after that edge.
- R6: A return while `cwp_o` is 0 leaves the pointer at 0. `unf_o` is 1 for exactly the one cycle after that edge.
- R7: If `call_i` and `ret_i` are high in the same cycle, the pointer holds and neither flag rises, even at window 0 or window 15.
- R8: Both read ports are combinational in the current window and independent of each other.
- R9: A write in the same cycle as a call or a return goes to the window that was current before the pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Advance to the next window |
| ret_i | input | 1 | Go back to the previous window |
| ra_addr_i | input | 3 | Read port A logical register |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 3 | Read port B logical register |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 3 | Write logical register |
| wr_data_i | input | 32 | Write data |
| cwp_o | output | 4 | Current window pointer |
| ovf_o | output | 1 | One-cycle pulse: call blocked at the last window |
| unf_o | output | 1 | One-cycle pulse: return blocked at window 0 |

## Verification
The bench aims at these corner cases:
- **Both window edges.** A design with an off-by-one wraps the pointer from 15 to 0 or from 0 to 15, or leaves a flag high for more than one cycle.
- **Call and return in the same cycle.** Here a wrong priority moves the pointer, or raises a flag at a boundary.
- **Write together with a move.** A design that translates the write address with the new pointer puts the data into the callee's window, and the caller later reads stale data.
- **Walk through all windows and back.** The bench goes to window 15 and back to 0, reading data it left in every window on the way. This catches translation that aliases windows or corrupts saved registers.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    WIN_HOLD = 2'd0,
    WIN_ADV  = 2'd1,
    WIN_BACK = 2'd2
  } win_op_e;

  function automatic win_op_e decode_op(input logic call, input logic ret);
    if (call && !ret)      return WIN_ADV;
    else if (ret && !call) return WIN_BACK;
    else                   return WIN_HOLD;
  endfunction
endpackage

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 16,
  localparam int CWP_W = $clog2(NUM_WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NUM_WIN - 1);

  logic [CWP_W-1:0] cwp_q;
  logic             ovf_q, unf_q;
  win_op_e          op;
  logic             at_top, at_bot;

  always_comb begin
    op     = decode_op(call_i, ret_i);
    at_top = (cwp_q == LAST_WIN);
    at_bot = (cwp_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= (op == WIN_ADV) && at_top;
      unf_q <= (op == WIN_BACK) && at_bot;
      case (op)
        WIN_ADV:  if (!at_top) cwp_q <= cwp_q + 1'b1;
        WIN_BACK: if (!at_bot) cwp_q <= cwp_q - 1'b1;
        default:  cwp_q <= cwp_q;
      endcase
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/wrf_addr_xlate.sv
module wrf_addr_xlate #(
  parameter int WIN_REGS = 8,
  parameter int NUM_WIN  = 16,
  localparam int LREG_W = $clog2(WIN_REGS),
  localparam int CWP_W  = $clog2(NUM_WIN),
  localparam int PIDX_W = $clog2(WIN_REGS * NUM_WIN)
) (
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [LREG_W-1:0] lreg_i,
  output logic [PIDX_W-1:0] pidx_o
);
  generate
    if ((1 << LREG_W) == WIN_REGS) begin : g_pow2
      // power-of-two window: base is a shift, so concatenate
      assign pidx_o = PIDX_W'({cwp_i, lreg_i});
    end else begin : g_mul
      assign pidx_o = PIDX_W'(cwp_i) * PIDX_W'(WIN_REGS) + PIDX_W'(lreg_i);
    end
  endgenerate
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int NRD    = 2,
  localparam int PIDX_W = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         we_i,
  input  logic [PIDX_W-1:0]            wr_idx_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [NRD-1:0][PIDX_W-1:0]   rd_idx_i,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  wsel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wsel
    assign wsel[g] = we_i && (wr_idx_i == PIDX_W'(g));
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wsel[i]) mem_q[i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_idx_i[p]];
  end
endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
  parameter int NUM_REGS = 128,
  parameter int WIN_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int NUM_WIN = NUM_REGS / WIN_REGS,
  localparam int LREG_W  = $clog2(WIN_REGS),
  localparam int CWP_W   = $clog2(NUM_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [LREG_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [LREG_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [LREG_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CWP_W-1:0]  cwp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int PIDX_W = $clog2(NUM_REGS);
  localparam int NRD    = 2;

  logic [CWP_W-1:0]              cwp;
  logic [NRD-1:0][LREG_W-1:0]    rd_lreg;
  logic [NRD-1:0][PIDX_W-1:0]    rd_pidx;
  logic [NRD-1:0][DATA_W-1:0]    rd_data;
  logic [PIDX_W-1:0]             wr_pidx;

  wrf_window_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .call_i (call_i),
    .ret_i  (ret_i),
    .cwp_o  (cwp),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
  );

  assign rd_lreg[0] = ra_addr_i;
  assign rd_lreg[1] = rb_addr_i;

  for (genvar p = 0; p < NRD; p++) begin : g_rx
    wrf_addr_xlate #(.WIN_REGS(WIN_REGS), .NUM_WIN(NUM_WIN)) u_rx (
      .cwp_i  (cwp),
      .lreg_i (rd_lreg[p]),
      .pidx_o (rd_pidx[p])
    );
  end

  // write uses the pre-move pointer: cwp only updates at the same edge
  wrf_addr_xlate #(.WIN_REGS(WIN_REGS), .NUM_WIN(NUM_WIN)) u_wx (
    .cwp_i  (cwp),
    .lreg_i (wr_addr_i),
    .pidx_o (wr_pidx)
  );

  wrf_storage #(.DEPTH(NUM_REGS), .DATA_W(DATA_W), .NRD(NRD)) u_mem (
    .clk_i     (clk_i),
    .we_i      (we_i),
    .wr_idx_i  (wr_pidx),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_pidx),
    .rd_data_o (rd_data)
  );

  assign ra_data_o = rd_data[0];
  assign rb_data_o = rd_data[1];
  assign cwp_o     = cwp;
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int NUM_WIN = 16,
  parameter int LREG_W  = 3,
  parameter int DATA_W  = 32,
  localparam int CWP_W = $clog2(NUM_WIN)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              call_i,
  input logic              ret_i,
  input logic              we_i,
  input logic [LREG_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [LREG_W-1:0] ra_addr_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [CWP_W-1:0]  cwp_o,
  input logic              ovf_o,
  input logic              unf_o
);
  localparam logic [CWP_W-1:0] LAST = CWP_W'(NUM_WIN - 1);

  p_call_adv_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && cwp_o != LAST) |=> (cwp_o == $past(cwp_o) + CWP_W'(1)));

  p_ret_back_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && cwp_o != '0) |=> (cwp_o == $past(cwp_o) - CWP_W'(1)));

  p_wr_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !call_i && !ret_i) |=>
      ((ra_addr_i != $past(wr_addr_i)) || (ra_data_o == $past(wr_data_i))));

  p_no_wrap_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && cwp_o == LAST) |=> (ovf_o && cwp_o == LAST));

  p_ovf_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(call_i && !ret_i && cwp_o == LAST) |=> !ovf_o);

  p_no_wrap_unf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && cwp_o == '0) |=> (unf_o && cwp_o == '0));

  p_unf_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ret_i && !call_i && cwp_o == '0) |=> !unf_o);

  p_both_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));

  p_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o}));
endmodule

bind wrf_top wrf_chk #(.NUM_WIN(NUM_WIN), .LREG_W(LREG_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .we_i      (we_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ra_addr_i (ra_addr_i),
  .ra_data_o (ra_data_o),
  .cwp_o     (cwp_o),
  .ovf_o     (ovf_o),
  .unf_o     (unf_o)
);

// File: tb/tb_wrf_top.sv
module tb_wrf_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        call_i, ret_i, we_i;
  logic [2:0]  ra_addr_i, rb_addr_i, wr_addr_i;
  logic [31:0] wr_data_i, ra_data_o, rb_data_o;
  logic [3:0]  cwp_o;
  logic        ovf_o, unf_o;

  always #2 clk_i = ~clk_i;

  wrf_top dut (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model
  logic [31:0] m_mem [128];
  bit          m_val [128];
  int          m_cwp;
  bit          m_ovf, m_unf;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        call;
    logic        ret;
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [2:0]  rb;
    logic [3:0]  ecwp;
    logic        eovf;
    logic        eunf;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 3'd0, 32'h0,  3'd0, 3'd0, 4'd0, 1'b0, 1'b1}, // R6 ret at 0
    '{1'b0, 1'b0, 1'b1, 3'd1, 32'h11, 3'd0, 3'd0, 4'd0, 1'b0, 1'b0}, // R4 write w0
    '{1'b1, 1'b0, 1'b1, 3'd2, 32'h22, 3'd1, 3'd0, 4'd1, 1'b0, 1'b0}, // R9 write+call
    '{1'b0, 1'b0, 1'b1, 3'd1, 32'h33, 3'd1, 3'd2, 4'd1, 1'b0, 1'b0}, // R4 write w1
    '{1'b1, 1'b1, 1'b0, 3'd0, 32'h0,  3'd1, 3'd1, 4'd1, 1'b0, 1'b0}, // R7 both
    '{1'b0, 1'b1, 1'b0, 3'd0, 32'h0,  3'd1, 3'd1, 4'd0, 1'b0, 1'b0}, // R3 ret
    '{1'b0, 1'b0, 1'b0, 3'd0, 32'h0,  3'd1, 3'd2, 4'd0, 1'b0, 1'b0}, // R8 reads
    '{1'b1, 1'b1, 1'b0, 3'd0, 32'h0,  3'd1, 3'd2, 4'd0, 1'b0, 1'b0}  // R7 both at 0
  };

  // drive at negedge, check reads before edge, check pointer/flags at next negedge
  task automatic step(input logic c, input logic r, input logic w, input logic [2:0] wa,
                      input logic [31:0] wd, input logic [2:0] ra, input logic [2:0] rb);
    string tag;
    int ia, ib;
    call_i = c; ret_i = r; we_i = w; wr_addr_i = wa; wr_data_i = wd;
    ra_addr_i = ra; rb_addr_i = rb;
    #1;
    ia = m_cwp * 8 + int'(ra);
    ib = m_cwp * 8 + int'(rb);
    if (m_val[ia]) chk("R8 port A", ra_data_o, m_mem[ia]);
    if (m_val[ib]) chk("R8 port B", rb_data_o, m_mem[ib]);
    if (c && r)                tag = "R7";
    else if (c && m_cwp == 15) tag = "R5";
    else if (r && m_cwp == 0)  tag = "R6";
    else if (w && (c || r))    tag = "R9";
    else if (c)                tag = "R2";
    else if (r)                tag = "R3";
    else                       tag = "R4";
    @(posedge clk_i);
    if (w) begin
      m_mem[m_cwp * 8 + int'(wa)] = wd;
      m_val[m_cwp * 8 + int'(wa)] = 1'b1;
    end
    m_ovf = c && !r && m_cwp == 15;
    m_unf = r && !c && m_cwp == 0;
    if (c && !r && m_cwp != 15) m_cwp++;
    else if (r && !c && m_cwp != 0) m_cwp--;
    @(negedge clk_i);
    chk({tag, " cwp"}, 32'(cwp_o), 32'(m_cwp));
    chk({tag, " ovf"}, 32'(ovf_o), 32'(m_ovf));
    chk({tag, " unf"}, 32'(unf_o), 32'(m_unf));
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) m_val[i] = 1'b0;
    m_cwp = 0; m_ovf = 0; m_unf = 0;
    rst_ni = 1'b0; call_i = 1'b1; ret_i = 1'b0; we_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; ra_addr_i = '0; rb_addr_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset cwp", 32'(cwp_o), 32'd0);
    chk("R1 reset flags", 32'({ovf_o, unf_o}), 32'd0);
    call_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // vector table
    for (int v = 0; v < NV; v++) begin
      step(VECS[v].call, VECS[v].ret, VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].ra, VECS[v].rb);
      chk("R2/R3 table cwp", 32'(cwp_o), 32'(VECS[v].ecwp));
      chk("R5 table ovf", 32'(ovf_o), 32'(VECS[v].eovf));
      chk("R6 table unf", 32'(unf_o), 32'(VECS[v].eunf));
    end

    // walk up to the last window, writing r0 in each window as it is left (R9)
    for (int i = 1; i <= 15; i++) step(1'b1, 1'b0, 1'b1, 3'd0, 32'h100 + 32'(i), 3'd0, 3'd0);
    chk("R2 top", 32'(cwp_o), 32'd15);
    step(1'b0, 1'b0, 1'b1, 3'd7, 32'hABCD, 3'd7, 3'd0); // R4 physical 127
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd7, 3'd7);
    chk("R4 phys127", ra_data_o, 32'hABCD);
    step(1'b1, 1'b0, 1'b0, 3'd0, 32'h0, 3'd7, 3'd0);    // R5 overflow
    chk("R5 ovf set", 32'(ovf_o), 32'd1);
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd7, 3'd0);
    chk("R5 ovf one cycle", 32'(ovf_o), 32'd0);
    step(1'b1, 1'b1, 1'b0, 3'd0, 32'h0, 3'd7, 3'd0);    // R7 at top
    chk("R7 top hold", 32'(cwp_o), 32'd15);

    // walk back down, reading saved r0 of each window (R3)
    for (int i = 15; i >= 1; i--) step(1'b0, 1'b1, 1'b0, 3'd0, 32'h0, 3'd0, 3'd1);
    step(1'b0, 1'b0, 1'b0, 3'd0, 32'h0, 3'd1, 3'd2);
    chk("R3 restored w0 r1", ra_data_o, 32'h11);
    chk("R9 w0 r2 write with call", rb_data_o, 32'h22);
    chk("R3 bottom", 32'(cwp_o), 32'd0);

    // asynchronous reset mid-run with call held
    step(1'b1, 1'b0, 1'b0, 3'd0, 32'h0, 3'd0, 3'd0);
    step(1'b1, 1'b0, 1'b0, 3'd0, 32'h0, 3'd0, 3'd0);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async cwp", 32'(cwp_o), 32'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 call ignored in reset", 32'(cwp_o), 32'd0);
    chk("R1 flags in reset", 32'({ovf_o, unf_o}), 32'd0);
    call_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule